// File: doc/BRIEF.md
# Windowed Extended-RAM Access Port with Auto-Increment

This block gives a host on a byte-wide register bus access to a battery-backed scratch RAM that has no direct mapping of its own. The host first selects the upper register bank by setting a bank bit. It then loads a RAM pointer through a low pointer register and a high pointer register. After that it moves bytes through one data register. If the streaming bit is set, the pointer steps by one after every data-register access. A whole buffer can then be written or read by repeating accesses to a single offset.

The RAM holds `RAM_BYTES` bytes, a power of two from 128 to 8192. When the RAM holds 256 bytes or fewer, only the low pointer register is in use. A build with `BURST_EN = 0` still stores and returns the streaming bit, but the bit never moves the pointer. Reads return data combinationally from the current offset and pointer. Writes and pointer steps take effect at the rising clock edge that ends the access.

Top module: `xram_port`

## Requirements
- R1: After reset the bank bit is 0, the streaming bit is 0 and the RAM pointer is 0. RAM contents are not reset.
- R2: Offset 0x0A is decoded in both banks. Bit 4 is the bank bit and is read/write. All other bits of this register read 0.
- R3: While the bank bit is 0, accesses to offsets 0x4A, 0x50, 0x51 and 0x53 are not claimed: `bus_hit` is 0 and `bus_rdata` is 0. Such accesses change neither the pointer, the streaming bit nor any RAM byte. Any access that is not claimed returns 0.
- R4: In bank 1, offset 0x50 reads and writes pointer bits 7:0. Offset 0x51 reads and writes pointer bits above bit 7, right-aligned. High register bits beyond the pointer width read 0.
- R5: In bank 1, a write to offset 0x53 stores the byte at the current pointer. A read of 0x53 returns the byte at the current pointer during the same bus cycle.
- R6: With the streaming bit at 0, accesses to offset 0x53 leave the pointer unchanged.
- R7: In bank 1, bit 5 of offset 0x4A is the streaming bit, and the other bits of that register read 0. When the bit is 1 and `BURST_EN = 1`, every read or write of 0x53 adds one to the pointer after the access.
- R8: A pointer step from `RAM_BYTES-1` wraps the pointer to 0.
- R9: With `RAM_BYTES` of 256 or less, offset 0x51 reads 0 and writes to it have no effect. Pointer bits above the pointer width in offset 0x50 read 0.
- R10: With `BURST_EN = 0`, the streaming bit still reads back as written, but accesses to 0x53 never move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and RAM clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_en | input | 1 | Access strobe, one access per cycle while high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access (0 when not claimed) |
| bus_hit | output | 1 | High when the current access decodes to a register of this block |

## Verification
A wrong pointer shows up at once in the next read of offset 0x50/0x51. It also shows up as a wrong byte from 0x53 on the very next data read, because the read path has no pipeline stage. A wrong step count in a burst therefore corrupts every later streamed byte. After a full-size burst, the pointer would not be back at 0, which is visible one access later. A gating error shows up in the same cycle as a non-zero `bus_rdata` or a raised `bus_hit` in bank 0. The error also appears later as a pointer or RAM byte that changed when it should not have.

// File: rtl/xram_pkg.sv
package xram_pkg;
  localparam logic [6:0] OFS_CTLA  = 7'h0A;
  localparam logic [6:0] OFS_CTL4A = 7'h4A;
  localparam logic [6:0] OFS_PLO   = 7'h50;
  localparam logic [6:0] OFS_PHI   = 7'h51;
  localparam logic [6:0] OFS_DAT   = 7'h53;
  localparam int BANK_BIT   = 4;
  localparam int STREAM_BIT = 5;

  typedef struct packed {
    logic ctla;
    logic ctl4a;
    logic plo;
    logic phi;
    logic dat;
  } xram_sel_t;
endpackage

// File: rtl/xram_decode.sv
module xram_decode
  import xram_pkg::*;
(
  input  logic       en,
  input  logic       bank,
  input  logic [6:0] addr,
  output xram_sel_t  sel,
  output logic       hit
);
  always_comb begin
    sel = '0;
    if (en) begin
      sel.ctla = (addr == OFS_CTLA);
      if (bank) begin
        sel.ctl4a = (addr == OFS_CTL4A);
        sel.plo   = (addr == OFS_PLO);
        sel.phi   = (addr == OFS_PHI);
        sel.dat   = (addr == OFS_DAT);
      end
    end
    hit = |sel;
  end
endmodule

// File: rtl/xram_ptr.sv
module xram_ptr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          step,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] ptr_q,
  output logic [7:0]    lo_rd,
  output logic [7:0]    hi_rd
);
  logic [AW-1:0] ptr_d;
  logic          ptr_ce;

  assign ptr_ce = ld_lo | ld_hi | step;

  generate
    if (AW > 8) begin : g_wide
      always_comb begin
        ptr_d = ptr_q;
        if (ld_lo)      ptr_d[7:0]    = wdata;
        else if (ld_hi) ptr_d[AW-1:8] = wdata[AW-9:0];
        else if (step)  ptr_d         = AW'(ptr_q + 1'b1);
      end
      assign hi_rd = 8'(ptr_q[AW-1:8]);
    end else begin : g_narrow
      always_comb begin
        ptr_d = ptr_q;
        if (ld_lo)     ptr_d = wdata[AW-1:0];
        else if (step) ptr_d = AW'(ptr_q + 1'b1);
      end
      assign hi_rd = 8'h00;
    end
  endgenerate

  assign lo_rd = 8'(ptr_q);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     ptr_q <= '0;
    else if (ptr_ce) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/xram_mem.sv
module xram_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/xram_port.sv
module xram_port
  import xram_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  parameter bit BURST_EN  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [6:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_hit
);
  localparam int AW = $clog2(RAM_BYTES);

  logic [1:0]    rst_sync_q;
  logic          srst_n;
  xram_sel_t     sel;
  logic          bank_q, bank_d;
  logic          burst_q, burst_d;
  logic          stream_act;
  logic [AW-1:0] addr_q;
  logic [7:0]    lo_rd, hi_rd, mem_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  xram_decode u_dec (
    .en   (bus_en),
    .bank (bank_q),
    .addr (bus_addr),
    .sel  (sel),
    .hit  (bus_hit)
  );

  always_comb begin
    bank_d  = bank_q;
    burst_d = burst_q;
    if (sel.ctla  && bus_we) bank_d  = bus_wdata[BANK_BIT];
    if (sel.ctl4a && bus_we) burst_d = bus_wdata[STREAM_BIT];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bank_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      if (sel.ctla)  bank_q  <= bank_d;
      if (sel.ctl4a) burst_q <= burst_d;
    end
  end

  generate
    if (BURST_EN) begin : g_stream
      assign stream_act = burst_q;
    end else begin : g_nostream
      assign stream_act = 1'b0;
    end
  endgenerate

  xram_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .srst_n (srst_n),
    .ld_lo  (sel.plo & bus_we),
    .ld_hi  (sel.phi & bus_we),
    .step   (sel.dat & stream_act),
    .wdata  (bus_wdata),
    .ptr_q  (addr_q),
    .lo_rd  (lo_rd),
    .hi_rd  (hi_rd)
  );

  xram_mem #(.DEPTH(RAM_BYTES), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (sel.dat & bus_we),
    .addr  (addr_q),
    .wdata (bus_wdata),
    .rdata (mem_rd)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (sel.ctla)  bus_rdata[BANK_BIT]   = bank_q;
    if (sel.ctl4a) bus_rdata[STREAM_BIT] = burst_q;
    if (sel.plo)   bus_rdata = lo_rd;
    if (sel.phi)   bus_rdata = hi_rd;
    if (sel.dat)   bus_rdata = mem_rd;
  end
endmodule

// File: rtl/xram_port_chk.sv
module xram_port_chk #(
  parameter int AW       = 11,
  parameter bit BURST_EN = 1'b1
) (
  input logic          clk,
  input logic          srst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [6:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          bus_hit,
  input logic          bank_q,
  input logic          burst_q,
  input logic [AW-1:0] addr_q
);
  logic dat_acc;
  logic gated_ofs;
  assign dat_acc   = bus_en && bank_q && (bus_addr == 7'h53);
  assign gated_ofs = (bus_addr == 7'h4A) || (bus_addr == 7'h50) ||
                     (bus_addr == 7'h51) || (bus_addr == 7'h53);

  p_bank_wr_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_en && bus_we && bus_addr == 7'h0A) |=> (bank_q == $past(bus_wdata[4])));

  p_gate_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_en && !bank_q && gated_ofs) |-> (!bus_hit && bus_rdata == 8'h00));

  p_gate_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_en && !bank_q && gated_ofs) |=> ($stable(addr_q) && $stable(burst_q)));

  p_lo_wr_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_en && bus_we && bank_q && bus_addr == 7'h50) |=>
      (8'(addr_q) == 8'($past(bus_wdata) & 8'((1 << AW) - 1))));

  p_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (dat_acc && !burst_q) |=> $stable(addr_q));

  p_step_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (BURST_EN && dat_acc && burst_q) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

  p_nostep_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!BURST_EN && dat_acc) |=> $stable(addr_q));

  p_small_hi_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (AW <= 8 && bus_en && bank_q && bus_addr == 7'h51) |-> (bus_rdata == 8'h00));

  p_nohit_zero_r3: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_hit |-> (bus_rdata == 8'h00));
endmodule

bind xram_port xram_port_chk #(.AW(AW), .BURST_EN(BURST_EN)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_hit   (bus_hit),
  .bank_q    (bank_q),
  .burst_q   (burst_q),
  .addr_q    (addr_q)
);

// File: tb/xram_port_test.sv
`timescale 1ns/1ps
module xram_port_test;
  localparam int BIG   = 2048;
  localparam int SMALL = 128;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_main, en_small, we;
  logic [6:0] addr;
  logic [7:0] wdata;
  logic [7:0] rd_main, rd_small;
  logic       hit_main, hit_small;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [BIG];
  int  m_ptr;
  bit  m_burst;

  always #10 clk = ~clk;

  xram_port #(.RAM_BYTES(BIG), .BURST_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(en_main), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_main), .bus_hit(hit_main));

  xram_port #(.RAM_BYTES(SMALL), .BURST_EN(1'b0)) uut_small (
    .clk(clk), .rst_n(rst_n), .bus_en(en_small), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_small), .bus_hit(hit_small));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus(input bit tgt, input bit w, input logic [6:0] a,
                     input logic [7:0] d, output logic [7:0] r, output logic h);
    @(negedge clk);
    en_main  = !tgt;
    en_small = tgt;
    we = w; addr = a; wdata = d;
    #2;
    r = tgt ? rd_small : rd_main;
    h = tgt ? hit_small : hit_main;
    @(posedge clk);
    #1;
    en_main = 1'b0; en_small = 1'b0; we = 1'b0;
  endtask

  function automatic logic [7:0] exp_lo();
    return 8'(m_ptr & 8'hFF);
  endfunction
  function automatic logic [7:0] exp_hi();
    return 8'(m_ptr >> 8);
  endfunction

  task automatic set_ptr(input int p);
    logic [7:0] r; logic h;
    bus(0, 1, 7'h50, 8'(p), r, h);
    bus(0, 1, 7'h51, 8'(p >> 8), r, h);
    m_ptr = p % BIG;
  endtask

  task automatic dat_step();
    if (m_burst) m_ptr = (m_ptr + 1) % BIG;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r, b;
    logic h;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; en_main = 1'b0; en_small = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    bus(0, 0, 7'h0A, 8'h00, r, h); chk("R1 bank after reset", r, 8'h00);
    bus(0, 1, 7'h0A, 8'h10, r, h);
    bus(0, 0, 7'h50, 8'h00, r, h); chk("R1 ptr lo after reset", r, 8'h00);
    bus(0, 0, 7'h51, 8'h00, r, h); chk("R1 ptr hi after reset", r, 8'h00);
    bus(0, 0, 7'h4A, 8'h00, r, h); chk("R1 stream bit after reset", r, 8'h00);

    // R2 bank register readback
    bus(0, 0, 7'h0A, 8'h00, r, h); chk("R2 bank readback", r, 8'h10);
    bus(0, 1, 7'h0A, 8'hFF, r, h);
    bus(0, 0, 7'h0A, 8'h00, r, h); chk("R2 other bits zero", r, 8'h10);
    chk("R2 hit on 0x0A", 8'(h), 8'h01);

    // R4 pointer registers
    bus(0, 1, 7'h50, 8'hA5, r, h);
    bus(0, 1, 7'h51, 8'h07, r, h);
    bus(0, 0, 7'h50, 8'h00, r, h); chk("R4 lo readback", r, 8'hA5);
    bus(0, 0, 7'h51, 8'h00, r, h); chk("R4 hi readback", r, 8'h07);
    bus(0, 1, 7'h51, 8'hFF, r, h);
    bus(0, 0, 7'h51, 8'h00, r, h); chk("R4 hi unused bits", r, 8'h07);

    // R7 streaming fill of the whole RAM, then R8 wrap to 0
    set_ptr(0);
    bus(0, 1, 7'h4A, 8'hFF, r, h); m_burst = 1'b1;
    bus(0, 0, 7'h4A, 8'h00, r, h); chk("R7 stream bit readback", r, 8'h20);
    for (int i = 0; i < BIG; i++) begin
      b = 8'($urandom);
      bus(0, 1, 7'h53, b, r, h);
      m_mem[m_ptr] = b; dat_step();
    end
    bus(0, 0, 7'h50, 8'h00, r, h); chk("R8 lo after full burst", r, 8'h00);
    bus(0, 0, 7'h51, 8'h00, r, h); chk("R8 hi after full burst", r, 8'h00);
    // R5 streaming read-back of every byte
    for (int i = 0; i < BIG; i++) begin
      bus(0, 0, 7'h53, 8'h00, r, h);
      chk("R5 R7 burst read", r, m_mem[m_ptr]); dat_step();
    end

    // R8 read at the top address wraps
    set_ptr(BIG - 1);
    bus(0, 0, 7'h53, 8'h00, r, h); chk("R8 top byte", r, m_mem[BIG-1]); dat_step();
    bus(0, 0, 7'h50, 8'h00, r, h); chk("R8 lo wrapped", r, 8'h00);
    bus(0, 0, 7'h51, 8'h00, r, h); chk("R8 hi wrapped", r, 8'h00);

    // R6 streaming off: pointer held
    bus(0, 1, 7'h4A, 8'h00, r, h); m_burst = 1'b0;
    set_ptr(12'h3C7);
    bus(0, 1, 7'h53, 8'h5A, r, h); m_mem[m_ptr] = 8'h5A;
    bus(0, 0, 7'h53, 8'h00, r, h); chk("R5 same-cycle read", r, 8'h5A);
    bus(0, 0, 7'h50, 8'h00, r, h); chk("R6 lo held", r, 8'hC7);
    bus(0, 0, 7'h51, 8'h00, r, h); chk("R6 hi held", r, 8'h03);

    // R3 bank 0 gating
    bus(0, 1, 7'h0A, 8'h00, r, h);
    bus(0, 1, 7'h50, 8'h12, r, h); chk("R3 lo not claimed", 8'(h), 8'h00);
    bus(0, 1, 7'h51, 8'h01, r, h); chk("R3 hi not claimed", 8'(h), 8'h00);
    bus(0, 1, 7'h53, 8'h99, r, h); chk("R3 data not claimed", 8'(h), 8'h00);
    bus(0, 1, 7'h4A, 8'h20, r, h); chk("R3 ctl not claimed", 8'(h), 8'h00);
    bus(0, 0, 7'h53, 8'h00, r, h); chk("R3 read data zero", r, 8'h00);
    bus(0, 0, 7'h50, 8'h00, r, h); chk("R3 read lo zero", r, 8'h00);
    bus(0, 1, 7'h0A, 8'h10, r, h);
    bus(0, 0, 7'h50, 8'h00, r, h); chk("R3 lo unchanged", r, 8'hC7);
    bus(0, 0, 7'h51, 8'h00, r, h); chk("R3 hi unchanged", r, 8'h03);
    bus(0, 0, 7'h4A, 8'h00, r, h); chk("R3 stream unchanged", r, 8'h00);
    bus(0, 0, 7'h53, 8'h00, r, h); chk("R3 byte unchanged", r, 8'h5A);

    // Random mix R4 R5 R6 R7
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 6);
      b  = 8'($urandom);
      case (op)
        0: begin bus(0, 1, 7'h50, b, r, h); m_ptr = (m_ptr & 32'h700) | int'(b); end
        1: begin bus(0, 1, 7'h51, b, r, h); m_ptr = (m_ptr & 32'hFF) | (int'(b & 8'h07) << 8); end
        2: begin bus(0, 1, 7'h4A, b, r, h); m_burst = b[5]; end
        3: begin bus(0, 1, 7'h53, b, r, h); m_mem[m_ptr] = b; dat_step(); end
        4: begin bus(0, 0, 7'h53, 8'h00, r, h); chk("R5 random read", r, m_mem[m_ptr]); dat_step(); end
        default: begin
          bus(0, 0, 7'h50, 8'h00, r, h); chk("R4 R6 R7 random lo", r, exp_lo());
          bus(0, 0, 7'h51, 8'h00, r, h); chk("R4 R6 R7 random hi", r, exp_hi());
        end
      endcase
    end

    // R9 R10 on the small, non-streaming variant
    bus(1, 1, 7'h0A, 8'h10, r, h);
    bus(1, 1, 7'h50, 8'hFF, r, h);
    bus(1, 0, 7'h50, 8'h00, r, h); chk("R9 small lo masked", r, 8'h7F);
    bus(1, 1, 7'h51, 8'h33, r, h);
    bus(1, 0, 7'h51, 8'h00, r, h); chk("R9 small hi reads zero", r, 8'h00);
    bus(1, 0, 7'h50, 8'h00, r, h); chk("R9 small hi write ignored", r, 8'h7F);
    bus(1, 1, 7'h4A, 8'h20, r, h);
    bus(1, 0, 7'h4A, 8'h00, r, h); chk("R10 stream bit stored", r, 8'h20);
    bus(1, 1, 7'h50, 8'h05, r, h);
    bus(1, 1, 7'h53, 8'hC3, r, h);
    bus(1, 1, 7'h53, 8'h3C, r, h);
    bus(1, 0, 7'h50, 8'h00, r, h); chk("R10 pointer not stepped", r, 8'h05);
    bus(1, 0, 7'h53, 8'h00, r, h); chk("R10 last write at same byte", r, 8'h3C);
    bus(1, 0, 7'h50, 8'h00, r, h); chk("R10 pointer after read", r, 8'h05);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule